// File: doc/BRIEF.md
# Configuration Startup Sequencer

This block runs once configuration data has been loaded into the device. After a start trigger it counts through numbered startup phases, one per startup-clock edge. As it goes it asserts the global write enable for state elements and memories, releases the global three-state hold on output buffers, and lets go of the shared open-drain DONE line. Each of these three events has its own programmable phase.

The write enable and the three-state hold can each be set to fire at a fixed phase. They can instead wait until the sampled DONE line reads high, or stay at their reset value. The counter can be made to stall at a chosen phase until every selected clock-manager lock flag is asserted. The DONE pad input is sampled through one register, or through two when the pipeline option is set. All option inputs are expected to stay constant while a sequence runs.

Top module: `startup_seq`

## Requirements
- R1: While reset is held and after it, until a start is seen, `gwe_o` is 0, `gts_o` is 1, `done_oe_o` is 1 and `done_drv_o` is 0.
- R2: The clock edge that samples `start_i` high is startup edge 0, and the phase counter then reads 0. Without a stall the counter advances by one on each later edge, so after edge j it reads j. It holds at 7 once it gets there. A start seen while a sequence is running has no effect.
- R3: An event in phase mode (mode code 2'b00, phase setting N from 1 to 6) takes effect in the cycle the counter enters phase N. `gwe_o` rises, `gts_o` falls, and the DONE line is released. The DONE release always uses phase mode.
- R4: With `lock_wait_en_i` high and `lock_phase_i` = P (0 to 6), the counter stays at P while any lock bit whose mask bit is 1 reads 0. Lock bits with mask bit 0 are ignored. The counter advances on the first edge at which all masked locks read 1.
- R5: With `lock_wait_en_i` low, the lock inputs have no effect on the timing of any event.
- R6: In DONE-wait mode (mode code 2'b01), a running event fires on the edge at which the sampled DONE is 1. If `done_pad_i` rises just after startup edge k, the output changes after edge k+2 when `done_pipe_i` = 0, and after edge k+3 when `done_pipe_i` = 1.
- R7: In keep mode (mode codes 2'b10 and 2'b11), the output stays at its R1 value for the whole sequence.
- R8: After the DONE release, with `done_drive_i` = 0, `done_oe_o` is 0 so the pad floats up to its external pull-up. With `done_drive_i` = 1, `done_oe_o` is 1. In both cases `done_drv_o` is 1.
- R9: Once an event has taken effect it holds until reset. A synchronous reset at any point in a sequence returns the outputs to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Startup clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start trigger, sampled on the clock |
| lock_i | input | NUM_LOCKS | Clock-manager lock flags, synchronous to clk |
| lock_mask_i | input | NUM_LOCKS | 1 selects a lock flag for the stall |
| lock_wait_en_i | input | 1 | 1 enables the lock stall |
| lock_phase_i | input | 3 | Phase at which the stall applies (0 to 6) |
| done_phase_i | input | 3 | Phase of the DONE release (1 to 6) |
| we_mode_i | input | 2 | Write-enable mode: 00 phase, 01 DONE-wait, 1x keep |
| we_phase_i | input | 3 | Write-enable phase (1 to 6) |
| ts_mode_i | input | 2 | Three-state release mode, same codes |
| ts_phase_i | input | 3 | Three-state release phase (1 to 6) |
| done_drive_i | input | 1 | 1 drives DONE high after release |
| done_pipe_i | input | 1 | 1 adds a second DONE sampling register |
| done_pad_i | input | 1 | DONE pad input (wired-AND level) |
| gwe_o | output | 1 | Global write enable |
| gts_o | output | 1 | Global three-state hold, 1 = outputs high-impedance |
| done_oe_o | output | 1 | DONE pad output enable |
| done_drv_o | output | 1 | DONE pad output value |

## Verification
The bench runs every sequence against a cycle model of phase numbers. This exposes an event that fires one edge early or late because the counter-entry cycle was miscounted, and a stall that lets the counter slip one phase past the lock phase. Locks are raised one at a time, with an unmasked lock left low, to catch a stall that releases on the first lock or waits on an unselected one. The stall is also tried at phase 0, which a design that only compares against nonzero phases would skip. DONE arrives late from outside with and without the pipeline, which shows a missing or extra sampling stage as a one-cycle shift. Keep modes, the drive option, a repeated start and a reset in the middle of a run show outputs that change when they must not, or that never return to their idle values.

// File: rtl/startup_pkg.sv
`timescale 1ns/1ps
// Shared constants and encodings for the startup sequencer.
// Assumes the numbered phases run from 1 to LAST_PHASE and that one extra
// counter value marks the finished state.
package startup_pkg;
    localparam int unsigned LAST_PHASE = 6;
    localparam int unsigned PH_MAX     = LAST_PHASE + 1;
    localparam int unsigned PH_W       = $clog2(PH_MAX + 1);

    // Event mode codes, as seen on the mode option inputs.
    typedef enum logic [1:0] {
        EV_AT_PHASE = 2'b00,
        EV_ON_DONE  = 2'b01,
        EV_KEEP     = 2'b10,
        EV_KEEP_ALT = 2'b11
    } ev_mode_e;
endpackage

// File: rtl/startup_phase_ctr.sv
`timescale 1ns/1ps
// Phase counter with the lock stall.
// The counter sits at 0 until start is sampled. After that it moves up one
// phase per clock and saturates at PH_MAX. It holds at the programmed lock
// phase while any selected lock flag is low. Lock flags are assumed to be
// synchronous to clk already.
module startup_phase_ctr
    import startup_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NUM_LOCKS-1:0] lock_i,
    input  logic [NUM_LOCKS-1:0] lock_mask_i,
    input  logic                 lock_wait_en_i,
    input  logic [PH_W-1:0]      lock_phase_i,
    output logic                 run_o,
    output logic [PH_W-1:0]      phase_o,
    output logic [PH_W-1:0]      phase_next_o
);
    localparam logic [PH_W-1:0] PH_TOP = PH_W'(PH_MAX);

    logic            run_q;
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] phase_d;
    logic            locks_ok;
    logic            stall;

    // Purpose: decide whether the selected locks allow the counter to move.
    always_comb begin
        locks_ok = &(lock_i | ~lock_mask_i);
        stall    = run_q && lock_wait_en_i && (phase_q == lock_phase_i) && !locks_ok;
    end

    // Purpose: next phase value, either held, saturated or incremented.
    always_comb begin
        if (!run_q) begin
            phase_d = '0;
        end else if (stall || phase_q == PH_TOP) begin
            phase_d = phase_q;
        end else begin
            phase_d = phase_q + PH_W'(1);
        end
    end

    // Purpose: register the run flag and the phase count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            phase_q <= '0;
        end else begin
            run_q   <= run_q | start_i;
            phase_q <= phase_d;
        end
    end

    assign run_o        = run_q;
    assign phase_o      = phase_q;
    assign phase_next_o = phase_d;

    // R2: the counter stays at zero until a sequence runs.
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !run_q |-> (phase_q == '0));

    // R2: the counter never moves backwards during a run.
    a_r2_monotonic: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> (phase_q >= $past(phase_q)));

    // R4: a selected lock that is low at the lock phase holds the counter.
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q && lock_wait_en_i && phase_q == lock_phase_i &&
         ((lock_i & lock_mask_i) != lock_mask_i)) |=> (phase_q == $past(phase_q)));
endmodule

// File: rtl/startup_done_sync.sv
`timescale 1ns/1ps
// DONE pad sampling path.
// One register always samples the pad. A second register is used when the
// pipeline option is set, for a DONE line that rises slowly. The option is
// assumed to be static during a sequence.
module startup_done_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pipe_en_i,
    input  logic pad_i,
    output logic done_s_o
);
    logic stage1_q;
    logic stage2_q;

    // Purpose: shift the pad level through the two sampling registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else begin
            stage1_q <= pad_i;
            stage2_q <= stage1_q;
        end
    end

    // Purpose: pick the one-stage or two-stage sampled DONE.
    always_comb begin
        done_s_o = pipe_en_i ? stage2_q : stage1_q;
    end
endmodule

// File: rtl/startup_event.sv
`timescale 1ns/1ps
// One sticky startup event.
// The event fires in the cycle the counter enters the selected phase, or on
// the edge where the sampled DONE is high, or never (keep). Once fired it
// stays set until reset. The mode is assumed to be static during a sequence.
module startup_event
    import startup_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run_i,
    input  logic [PH_W-1:0] phase_next_i,
    input  logic [1:0]      mode_i,
    input  logic [PH_W-1:0] phase_sel_i,
    input  logic            done_s_i,
    output logic            fired_o
);
    logic     fired_q;
    logic     fire;
    ev_mode_e mode;

    // Purpose: evaluate the firing condition for the selected mode.
    always_comb begin
        mode = ev_mode_e'(mode_i);
        case (mode)
            EV_AT_PHASE: fire = run_i && (phase_next_i >= phase_sel_i);
            EV_ON_DONE:  fire = run_i && done_s_i;
            default:     fire = 1'b0;
        endcase
    end

    // Purpose: hold the event once it has fired.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fired_q <= 1'b0;
        end else begin
            fired_q <= fired_q | fire;
        end
    end

    assign fired_o = fired_q;

    // R9: a fired event never clears outside reset.
    a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fired_q |=> fired_q);

    // R7: keep mode never fires.
    a_r7_keep_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (!fired_q && mode_i[1]) |=> !fired_q);
endmodule

// File: rtl/startup_seq.sv
`timescale 1ns/1ps
// Startup sequencer top.
// Ties the phase counter, the DONE sampler and three event cells together.
// It maps the events onto the write enable, the three-state hold and the
// open-drain DONE pad controls. Option inputs are assumed static while a
// sequence runs, and lock flags are assumed synchronous to clk.
module startup_seq
    import startup_pkg::*;
#(
    parameter int unsigned NUM_LOCKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NUM_LOCKS-1:0] lock_i,
    input  logic [NUM_LOCKS-1:0] lock_mask_i,
    input  logic                 lock_wait_en_i,
    input  logic [PH_W-1:0]      lock_phase_i,
    input  logic [PH_W-1:0]      done_phase_i,
    input  logic [1:0]           we_mode_i,
    input  logic [PH_W-1:0]      we_phase_i,
    input  logic [1:0]           ts_mode_i,
    input  logic [PH_W-1:0]      ts_phase_i,
    input  logic                 done_drive_i,
    input  logic                 done_pipe_i,
    input  logic                 done_pad_i,
    output logic                 gwe_o,
    output logic                 gts_o,
    output logic                 done_oe_o,
    output logic                 done_drv_o
);
    logic            run;
    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] phase_next;
    logic            done_s;
    logic            we_fired;
    logic            ts_fired;
    logic            done_fired;

    startup_phase_ctr #(.NUM_LOCKS(NUM_LOCKS)) u_ctr (
        .clk            (clk),
        .rst_n          (rst_n),
        .start_i        (start_i),
        .lock_i         (lock_i),
        .lock_mask_i    (lock_mask_i),
        .lock_wait_en_i (lock_wait_en_i),
        .lock_phase_i   (lock_phase_i),
        .run_o          (run),
        .phase_o        (phase),
        .phase_next_o   (phase_next)
    );

    startup_done_sync u_dsync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pipe_en_i (done_pipe_i),
        .pad_i     (done_pad_i),
        .done_s_o  (done_s)
    );

    startup_event u_ev_we (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .phase_next_i (phase_next),
        .mode_i       (we_mode_i),
        .phase_sel_i  (we_phase_i),
        .done_s_i     (done_s),
        .fired_o      (we_fired)
    );

    startup_event u_ev_ts (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .phase_next_i (phase_next),
        .mode_i       (ts_mode_i),
        .phase_sel_i  (ts_phase_i),
        .done_s_i     (done_s),
        .fired_o      (ts_fired)
    );

    startup_event u_ev_done (
        .clk          (clk),
        .rst_n        (rst_n),
        .run_i        (run),
        .phase_next_i (phase_next),
        .mode_i       (EV_AT_PHASE),
        .phase_sel_i  (done_phase_i),
        .done_s_i     (done_s),
        .fired_o      (done_fired)
    );

    // Purpose: map events onto the global controls and the open-drain DONE pad.
    always_comb begin
        gwe_o      = we_fired;
        gts_o      = ~ts_fired;
        done_oe_o  = ~done_fired | done_drive_i;
        done_drv_o = done_fired;
    end

    // R3: in phase mode the write enable rises exactly at its phase.
    a_r3_gwe_at_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (we_mode_i == EV_AT_PHASE && $rose(gwe_o)) |-> (phase == we_phase_i));

    // R3: in phase mode the three-state hold drops exactly at its phase.
    a_r3_gts_at_phase: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_mode_i == EV_AT_PHASE && $fell(gts_o)) |-> (phase == ts_phase_i));

    // R3: the DONE line is released exactly at its phase.
    a_r3_done_at_phase: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_drv_o) |-> (phase == done_phase_i));
endmodule

// File: tb/startup_seq_tb_top.sv
`timescale 1ns/1ps
// Directed bench for the startup sequencer: each task configures, runs and
// checks one scenario against a per-cycle model of the startup edge count.
module startup_seq_tb_top;
    localparam int NL = 4;
    localparam int NEVER = 999;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [NL-1:0] lock = '0;
    logic [NL-1:0] lock_mask = '0;
    logic          lock_wait_en = 1'b0;
    logic [2:0]    lock_phase = '0;
    logic [2:0]    done_phase = 3'd1;
    logic [1:0]    we_mode = 2'b00;
    logic [2:0]    we_phase = 3'd1;
    logic [1:0]    ts_mode = 2'b00;
    logic [2:0]    ts_phase = 3'd1;
    logic          done_drive = 1'b0;
    logic          done_pipe = 1'b0;
    logic          done_pad = 1'b0;
    logic          gwe, gts, done_oe, done_drv;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    startup_seq #(.NUM_LOCKS(NL)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .lock_i(lock),
        .lock_mask_i(lock_mask), .lock_wait_en_i(lock_wait_en),
        .lock_phase_i(lock_phase), .done_phase_i(done_phase),
        .we_mode_i(we_mode), .we_phase_i(we_phase), .ts_mode_i(ts_mode),
        .ts_phase_i(ts_phase), .done_drive_i(done_drive),
        .done_pipe_i(done_pipe), .done_pad_i(done_pad), .gwe_o(gwe),
        .gts_o(gts), .done_oe_o(done_oe), .done_drv_o(done_drv)
    );

    task automatic chk(string req, string what, logic act, logic exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start = 1'b0; lock = '0; done_pad = 1'b0;
        tick(); tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic chk_idle(string req);
        chk(req, "gwe idle", gwe, 1'b0);
        chk(req, "gts idle", gts, 1'b1);
        chk(req, "done_oe idle", done_oe, 1'b1);
        chk(req, "done_drv idle", done_drv, 1'b0);
    endtask

    // Runs one sequence. *_at = startup edge after which the event shows;
    // *_j = startup edge after which the bench raises that input.
    task automatic run_seq(string req, int len, int we_at, int ts_at, int done_at,
                           int pad_j, int l0_j, int l1_j, int restart_j);
        start = 1'b1;
        tick();                       // startup edge 0
        start = 1'b0;
        for (int j = 0; j <= len; j++) begin
            if (j > 0) tick();
            chk(req, $sformatf("gwe edge %0d", j), gwe, j >= we_at);
            chk(req, $sformatf("gts edge %0d", j), gts, !(j >= ts_at));
            chk(req, $sformatf("done_oe edge %0d", j), done_oe,
                !(j >= done_at) || done_drive);
            chk(req, $sformatf("done_drv edge %0d", j), done_drv, j >= done_at);
            if (j == pad_j) done_pad = 1'b1;
            if (j == l0_j) lock[0] = 1'b1;
            if (j == l1_j) lock[1] = 1'b1;
            start = (j == restart_j);
        end
        start = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk_idle("R1");
        tick(); tick();
        chk_idle("R1");
    endtask

    // R2 R3 R9: plain phase ordering, a repeated start, long tail to saturation.
    task automatic t_phase_order();
        we_mode = 2'b00; we_phase = 3'd3; ts_mode = 2'b00; ts_phase = 3'd5;
        done_phase = 3'd2; done_drive = 1'b0; lock_wait_en = 1'b0;
        do_reset();
        run_seq("R3", 14, 3, 5, 2, NEVER, NEVER, NEVER, 4);
        chk("R9", "gwe sticky", gwe, 1'b1);
        do_reset();
        chk_idle("R9");
        we_phase = 3'd6; ts_phase = 3'd1; done_phase = 3'd6;
        do_reset();
        run_seq("R2", 10, 6, 1, 6, NEVER, NEVER, NEVER, NEVER);
    endtask

    // R4: stall at phase 2 on two masked locks arriving late, lock 2 unmasked.
    task automatic t_lock_stall();
        we_mode = 2'b00; we_phase = 3'd4; ts_mode = 2'b00; ts_phase = 3'd3;
        done_phase = 3'd2; lock_wait_en = 1'b1; lock_phase = 3'd2;
        lock_mask = 4'b0011;
        do_reset();
        run_seq("R4", 14, 10, 9, 2, NEVER, 5, 8, NEVER);
        // stall at phase 0
        lock_phase = 3'd0; lock_mask = 4'b0001;
        we_phase = 3'd1; ts_phase = 3'd2; done_phase = 3'd3;
        do_reset();
        run_seq("R4", 10, 5, 6, 7, NEVER, 4, NEVER, NEVER);
        lock_wait_en = 1'b0;
    endtask

    // R5: locks ignored when waiting is disabled.
    task automatic t_lock_off();
        lock_wait_en = 1'b0; lock_phase = 3'd1; lock_mask = 4'b1111;
        we_mode = 2'b00; we_phase = 3'd2; ts_phase = 3'd6; done_phase = 3'd1;
        do_reset();
        run_seq("R5", 8, 2, 6, 1, NEVER, NEVER, NEVER, NEVER);
        lock_mask = '0;
    endtask

    // R6: DONE-wait with and without the pipeline; pad rises after edge 6.
    task automatic t_done_wait();
        we_mode = 2'b01; ts_mode = 2'b01; done_phase = 3'd3; done_drive = 1'b0;
        done_pipe = 1'b0;
        do_reset();
        run_seq("R6", 11, 8, 8, 3, 6, NEVER, NEVER, NEVER);
        done_pipe = 1'b1; ts_mode = 2'b00; ts_phase = 3'd2;
        do_reset();
        run_seq("R6", 11, 9, 2, 3, 6, NEVER, NEVER, NEVER);
        done_pipe = 1'b0;
    endtask

    // R7 R8: keep modes and actively driven DONE.
    task automatic t_keep_drive();
        we_mode = 2'b10; ts_mode = 2'b11; done_phase = 3'd4; done_drive = 1'b1;
        do_reset();
        run_seq("R7", 10, NEVER, NEVER, 4, 2, NEVER, NEVER, NEVER);
        chk("R8", "driven done_oe", done_oe, 1'b1);
        chk("R8", "driven done_drv", done_drv, 1'b1);
        done_drive = 1'b0;
        tick();
        chk("R8", "released done_oe", done_oe, 1'b0);
        // R9: reset in the middle of a run returns to idle
        we_mode = 2'b00; we_phase = 3'd1; ts_mode = 2'b00; ts_phase = 3'd1;
        do_reset();
        run_seq("R9", 3, 1, 1, 4, NEVER, NEVER, NEVER, NEVER);
        do_reset();
        chk_idle("R9");
    endtask

    initial begin
        t_reset_state();
        t_phase_order();
        t_lock_stall();
        t_lock_off();
        t_done_wait();
        t_keep_drive();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        #(20 * 200000);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule